// File: doc/BRIEF.md
# Serial Flash Status Register Write Controller

This block holds the 8-bit status register of a serial flash device's SPI slave and the path that writes to it. A host selects the device by pulling chip-select low, clocks an instruction byte in on the serial input and, for a status write, a data byte after it. SCK, chip-select, the serial input and the write-protect pin are brought into the system clock domain through a synchroniser chain. Their edges are then detected, and a single state machine decodes the bytes that the SCK edges deliver.

A status write is committed only on the chip-select rising edge that follows exactly two whole bytes. It also requires that the write-enable latch was set beforehand, and it is refused when the hardware protection condition holds. An accepted write starts a self-timed busy interval counted in system clock cycles. At the end of that interval the busy flag and the write-enable latch both clear. A read-status command shifts the live register out on the serial output, so a host can poll the busy flag while a write is running.

FSM states: `ST_IDLE` (deselected), `ST_CMD` (collecting the instruction byte), `ST_WDATA` (collecting the status data byte), `ST_WEND` (two bytes received, commit pending on deselect), `ST_WENEND` (enable instruction received, latch set pending on deselect), `ST_READ` (shifting status out), `ST_SKIP` (command refused or overrun, nothing happens until deselect). Transitions:
- Any state goes to `ST_IDLE` whenever the device is deselected.
- `ST_IDLE` goes to `ST_CMD` on select.
- `ST_CMD` leaves on the completed byte. It goes to `ST_WENEND` for 0x06, to `ST_WDATA` for 0x01 and to `ST_READ` for 0x05. It goes to `ST_SKIP` for any other code, or for 0x06 and 0x01 while busy.
- `ST_WDATA` goes to `ST_WEND` on the completed byte.
- `ST_WEND` and `ST_WENEND` go to `ST_SKIP` on any further SCK rise.

Top module: `spi_status_wctl`

## Requirements
- R1: After reset the status output reads 0x00 and the serial output is 0.
- R2: The status layout is bit7 = write-disable guard, bit6 = quad enable, bits 5..2 = four protect bits, bit1 = write-enable latch, bit0 = busy. A write never takes bits 1..0 from the data byte.
- R3: A status write (opcode 0x01 followed by a data byte) with exactly 16 bits is accepted when the latch is set and the device is not hardware protected. Chip-select rising then loads bits 7..2 from data bits 7..2.
- R4: A status write issued while the write-enable latch is 0 changes nothing and does not set busy.
- R5: When the write-protect pin is 0 and bit7 is 1, a status write is refused even with the latch set, and the latch stays 1.
- R6: With the pin at 1 and bit7 at 1, or with bit7 at 0 and either pin level, an enabled status write is accepted and may change bit7 and the protect bits.
- R7: If chip-select rises after any bit count other than a whole instruction, the command is dropped. A write-enable needs exactly 8 bits and a status write exactly 16. The register and latch keep their values and busy is not set.
- R8: An accepted write holds busy at 1 for exactly TW_CYCLES system clocks from the commit. When busy returns to 0, the write-enable latch is cleared in the same cycle.
- R9: While busy is 1, write-enable and status-write commands are ignored.
- R10: Read status (opcode 0x05) drives the register on the serial output MSB first. The output changes after SCK falling edges, repeats every 8 bits, and shows the live busy flag. While deselected the output is 0.
- R11: The serial input is sampled on SCK rising edges, most significant bit first. A write-enable (opcode 0x06) with exactly 8 bits sets bit1 on deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data out |
| status_o | output | 8 | Current status register contents |

## Verification
Pin changes reach the state machine after two synchroniser stages plus one edge-detect register. A commit or latch set therefore appears on `status_o` about four system clocks after chip-select rises. The bench waits eight clocks after deselect before comparing the register. The busy flag is checked once shortly after the commit and again after TW_CYCLES plus a margin; the checker counts the exact busy length. Serial-output bits change about four clocks after an SCK fall. The bench holds each SCK phase for six clocks and captures the output at its own SCK rising edge, when the bit has settled.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_RDSR = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_WEND,
        ST_WENEND,
        ST_READ,
        ST_SKIP
    } spi_st_e;
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
    parameter int N = 4,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST[g]}};
                else        chain <= {chain[STAGES-2:0], d[g]};
            end
            assign q[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi_sr_rx.sv
module spi_sr_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       sck_rise,
    input  logic       si,
    output logic [7:0] byte_q,
    output logic       byte_done
);
    logic [2:0] bit_cnt;
    logic [6:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_q    <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[5:0], si};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_q    <= {shreg, si};
                    byte_done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_sr_timer.sv
module spi_sr_timer #(
    parameter int TW_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TW_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(TW_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spi_status_wctl.sv
module spi_status_wctl
    import spi_sr_pkg::*;
#(
    parameter int TW_CYCLES = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic       wp_n,
    output logic       so,
    output logic [7:0] status_o
);
    logic [3:0] pin_s;
    logic       sck_q, cs_q;
    logic       sck_rise, sck_fall, cs_rise, sel, si_s, wp_s;
    logic [7:0] byte_q;
    logic       byte_done;
    logic       busy, tw_done, wr_ok;
    logic [5:0] sr_hi, wdata;
    logic       wel;
    logic [2:0] rd_idx;
    spi_st_e    state, nxt;

    spi_sr_sync #(.N(4), .STAGES(SYNC_STAGES), .RST(4'b1100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({wp_n, cs_n, si, sck}), .q(pin_s)
    );

    assign si_s = pin_s[1];
    assign wp_s = pin_s[3];
    assign sel  = ~pin_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= pin_s[0];
            cs_q  <= pin_s[2];
        end
    end

    assign sck_rise = pin_s[0] & ~sck_q;
    assign sck_fall = ~pin_s[0] & sck_q;
    assign cs_rise  = pin_s[2] & ~cs_q;

    spi_sr_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise), .si(si_s),
        .byte_q(byte_q), .byte_done(byte_done)
    );

    assign wr_ok = cs_rise && (state == ST_WEND) && wel && !busy
                   && !(!wp_s && sr_hi[5]);

    spi_sr_timer #(.TW_CYCLES(TW_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(wr_ok), .busy(busy), .done(tw_done)
    );

    assign status_o = {sr_hi, wel, busy};

    // next-state decode
    always_comb begin
        nxt = state;
        if (!sel) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_CMD;
                ST_CMD: if (byte_done) begin
                    if (byte_q == OP_WREN)      nxt = busy ? ST_SKIP : ST_WENEND;
                    else if (byte_q == OP_WRSR) nxt = busy ? ST_SKIP : ST_WDATA;
                    else if (byte_q == OP_RDSR) nxt = ST_READ;
                    else                        nxt = ST_SKIP;
                end
                ST_WDATA:  if (byte_done) nxt = ST_WEND;
                ST_WEND:   if (sck_rise)  nxt = ST_SKIP;
                ST_WENEND: if (sck_rise)  nxt = ST_SKIP;
                ST_READ:   nxt = ST_READ;
                ST_SKIP:   nxt = ST_SKIP;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered outputs and status contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_hi  <= '0;
            wdata  <= '0;
            wel    <= 1'b0;
            so     <= 1'b0;
            rd_idx <= 3'd7;
        end else begin
            if (byte_done && state == ST_WDATA) wdata <= byte_q[7:2];
            if (byte_done && state == ST_CMD && byte_q == OP_RDSR) rd_idx <= 3'd7;

            if (!sel) begin
                so <= 1'b0;
            end else if (state == ST_READ && sck_fall) begin
                so     <= status_o[rd_idx];
                rd_idx <= rd_idx - 3'd1;
            end

            if (tw_done)
                wel <= 1'b0;
            else if (cs_rise && state == ST_WENEND && !busy)
                wel <= 1'b1;

            if (wr_ok) sr_hi <= wdata;
        end
    end
endmodule

// File: rtl/spi_status_wctl_chk.sv
module spi_status_wctl_chk #(
    parameter int TW_CYCLES = 500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_s,
    input logic       cs_rise,
    input logic       sel,
    input logic       so,
    input logic [7:0] status
);
    localparam int CW = $clog2(TW_CYCLES + 2) + 1;
    logic [CW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_len <= '0;
        else if (status[0]) busy_len <= busy_len + 1'b1;
        else                busy_len <= '0;
    end

    // R3 R4 R5: upper bits move only on an enabled, unprotected deselect while idle
    p_sr_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[7:2]) |-> $past(cs_rise && status[1] && !status[0]
                                        && !(!wp_s && status[7])));

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> (busy_len == CW'(TW_CYCLES)));

    p_wel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);

    p_busy_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> status[1]);

    p_no_wel_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> !$past(status[0]));

    p_wel_on_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(cs_rise));

    p_so_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && $past(!sel)) |-> !so);
endmodule

bind spi_status_wctl spi_status_wctl_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wp_s(wp_s), .cs_rise(cs_rise),
    .sel(sel), .so(so), .status(status_o)
);

// File: tb/spi_status_wctl_tb_top.sv
module spi_status_wctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 500;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
    logic so;
    logic [7:0] status_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [5:0] m_hi = '0;
    logic m_wel = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_status_wctl #(.TW_CYCLES(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .wp_n(wp_n), .so(so), .status_o(status_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_sr(input logic busy);
        return {m_hi, m_wel, busy};
    endfunction

    function automatic logic wr_allowed(input logic wp);
        return m_wel && !(!wp && m_hi[5]);
    endfunction

    task automatic spi_bits(input logic [23:0] v, input int n, output logic [23:0] rx);
        rx = '0;
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            si = v[i];
            repeat (HP) @(negedge clk);
            sck = 1'b1;
            rx = {rx[22:0], so};
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic settle();
        repeat (TW + 20) @(negedge clk);
    endtask

    task automatic do_wren();
        logic [23:0] rx;
        spi_bits(24'h06, 8, rx);
        m_wel = 1'b1;
    endtask

    task automatic do_wrsr(input logic [7:0] d, input string req);
        logic [23:0] rx;
        logic ok;
        ok = wr_allowed(wp_n);
        spi_bits({16'h0, 8'h01, d} & 24'hFFFF, 16, rx);
        if (ok) begin
            m_hi = d[7:2];
            chk({req, " commit busy"}, status_o, model_sr(1'b1));
            settle();
            m_wel = 1'b0;
            chk({req, " after tW"}, status_o, model_sr(1'b0));
        end else begin
            chk({req, " refused"}, status_o, model_sr(1'b0));
        end
    endtask

    initial begin
        logic [23:0] rx;
        logic [7:0] d;
        int n, op;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        chk("R1 reset status", status_o, 8'h00);
        chk("R1 reset so", {7'h0, so}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4: write without latch
        do_wrsr(8'hFF, "R4");
        // R11: enable sets bit1
        do_wren();
        chk("R11 wren", status_o, model_sr(1'b0));
        // R7: misaligned write (12 bits)
        spi_bits(24'h01F, 12, rx);
        chk("R7 misaligned wrsr", status_o, model_sr(1'b0));
        // R3 R2: data low bits must not leak in
        do_wrsr(8'hBF, "R3 R2 R8");
        // R7: enable with 11 bits after latch cleared
        spi_bits(24'h035, 11, rx);
        chk("R7 misaligned wren", status_o, model_sr(1'b0));
        // R6: pin 1, guard 1 -> accepted
        do_wren();
        do_wrsr(8'hC4, "R6 wp1 guard1");
        // R5: pin 0, guard 1 -> refused, latch kept
        wp_n = 1'b0;
        repeat (4) @(negedge clk);
        do_wren();
        do_wrsr(8'h00, "R5 hpm");
        chk("R5 latch kept", {7'h0, status_o[1]}, 8'h01);
        // R6: pin 1 again releases; guard 0 with pin 0 accepted
        wp_n = 1'b1;
        repeat (4) @(negedge clk);
        do_wrsr(8'h3C, "R6 release");
        wp_n = 1'b0;
        repeat (4) @(negedge clk);
        do_wren();
        do_wrsr(8'h94, "R6 wp0 guard0");
        wp_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 R10: busy window behaviour
        do_wren();
        spi_bits(24'h0124, 16, rx);
        m_hi = 6'h09;
        chk("R8 busy set", status_o, model_sr(1'b1));
        spi_bits(24'h0500, 16, rx);
        chk("R10 read while busy", rx[7:0], model_sr(1'b1));
        spi_bits(24'h01FC, 16, rx);
        chk("R9 write ignored in busy", status_o, model_sr(1'b1));
        settle();
        m_wel = 1'b0;
        chk("R9 R8 value kept", status_o, model_sr(1'b0));
        spi_bits(24'h050000, 24, rx);
        chk("R10 read repeat a", rx[15:8], model_sr(1'b0));
        chk("R10 read repeat b", rx[7:0], model_sr(1'b0));

        // random mix
        for (int k = 0; k < 30; k++) begin
            op = int'($urandom % 4);
            wp_n = 1'($urandom % 2);
            repeat (4) @(negedge clk);
            d = 8'($urandom);
            case (op)
                0: begin
                    do_wren();
                    chk("R11 rand wren", status_o, model_sr(1'b0));
                end
                1: do_wrsr(d, "R3 R5 R6 rand");
                2: begin
                    n = 9 + int'($urandom % 15);
                    if (n == 16) n = 17;
                    spi_bits({8'h01, d, 8'hA5} >> (24 - n), n, rx);
                    chk("R7 rand misaligned", status_o, model_sr(1'b0));
                end
                default: begin
                    spi_bits(24'h0500, 16, rx);
                    chk("R10 rand read", rx[7:0], model_sr(1'b0));
                end
            endcase
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule